// File: doc/BRIEF.md
# Memory Command and Write-Data Pairing Front End

This block sits on the controller side of a user memory port. It takes commands on one handshaked channel and write data on a second channel. Each channel has its own FIFO and applies backpressure independently. The block assembles write data into whole bursts. It then matches each write command with the oldest complete burst and hands single, self-contained operations to a downstream memory-operation port. Reads pass through with no data dependency. Every operation leaves in the order its command was accepted.

One user-clock cycle carries one beat, and one beat is a full burst of eight memory-width transfers. A write burst may therefore span one beat or several beats, set by a parameter whose default is two, and a last-beat flag closes it. Write data may come before its command, in the same cycle, or up to three cycles after it. The block flags data that comes later than that. It also flags malformed bursts and unsupported command codes on a four-bit error output. That output pulses for one cycle, in the cycle after the offending event.

Top module: `mem_cmd_pair_frontend`

## Requirements
- R1: A command is taken only in a cycle with `cmd_valid` and `cmd_ready` both high; `cmd_ready` is low exactly when the command FIFO holds `CMD_DEPTH` (default 4) entries, and a command offered while it is low is not taken.
- R2: Command code 0 is a write and code 1 is a read; any other code is taken, produces no operation, and raises `err_flags[0]` for one cycle, one cycle later.
- R3: A data beat is taken only in a cycle with `wd_valid` and `wd_ready` both high; `wd_ready` is low exactly when the data FIFO holds `DATA_DEPTH` (default 4) complete bursts.
- R4: A burst is `BEATS` beats (default 2), and `wd_last` is high on its final beat only; with `BEATS` = 1 every beat carries `wd_last`.
- R5: A write is offered on `op_valid` with `op_write`=1 only when a write command is at the head of the command FIFO and a complete burst is at the head of the data FIFO; `op_data` and `op_mask` carry beat 0 in their least significant slice, and a mask bit of 1 means the byte is not written.
- R6: A read is offered with `op_write`=0 as soon as it reaches the head of the command FIFO, whatever the state of the data channel.
- R7: Operations leave in command-acceptance order, and while `op_valid` is high and `op_ready` low, `op_valid`, `op_write`, `op_addr`, `op_data` and `op_mask` stay unchanged.
- R8: If the first beat of a write's burst is taken more than `MAX_SKEW` (default 3) cycles after the write command, `err_flags[1]` pulses once for that command; the write is still issued with that burst.
- R9: A burst whose first beat comes before its write command, in the same cycle, or within `MAX_SKEW` cycles after it raises no error.
- R10: A `wd_last` before beat `BEATS`-1 raises `err_flags[2]` and closes the burst; the missing beats carry zero data and an all-ones mask.
- R11: A final beat (index `BEATS`-1) without `wd_last` raises `err_flags[3]` and closes the burst anyway; the next beat starts a new burst.
- R12: After reset `cmd_ready` and `wd_ready` are high, `op_valid` is low and `err_flags` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Command FIFO has room |
| cmd_code | input | 3 | 0 write, 1 read, others unsupported |
| cmd_addr | input | AW | Command address |
| wd_valid | input | 1 | Write-data strobe |
| wd_ready | output | 1 | Data FIFO has room |
| wd_data | input | DW | One write-data beat |
| wd_mask | input | DW/8 | Byte mask, 1 = byte not written |
| wd_last | input | 1 | Final beat of a burst |
| op_valid | output | 1 | Operation offered downstream |
| op_ready | input | 1 | Downstream accepts the operation |
| op_write | output | 1 | 1 write, 0 read |
| op_addr | output | AW | Operation address |
| op_data | output | BEATS*DW | Burst data, beat 0 in low bits |
| op_mask | output | BEATS*DW/8 | Burst byte mask, beat 0 in low bits |
| err_flags | output | 4 | Pulses: [0] bad code, [1] late data, [2] short burst, [3] long burst |

## Verification
The hardest situation to reach is a mismatch between the two channels that still has to end in correct pairing. Examples are bursts parked in the data FIFO long before any write command, or a write whose data shows up past the skew window while older and younger commands wait around it. The bench fills the data FIFO with bursts that have no commands. It then fills the command FIFO with reads while the downstream port is stalled. It presents the writes only after the reads drain, and checks that every early burst lands on the right write with no late-data flag. In separate scenarios it delays data on purpose by a counted number of cycles, and it interleaves writes and a read under backpressure to check order and output stability.

// File: rtl/mem_pair_pkg.sv
// Shared constants for the command / write-data pairing front end.
package mem_pair_pkg;
    // Command codes seen on the command channel.
    localparam logic [2:0] CODE_WRITE = 3'd0;
    localparam logic [2:0] CODE_READ  = 3'd1;

    // Bit positions inside the error pulse vector.
    localparam int ERR_BAD_CODE = 0;
    localparam int ERR_LATE     = 1;
    localparam int ERR_SHORT    = 2;
    localparam int ERR_LONG     = 3;
    localparam int ERR_W        = 4;
endpackage

// File: rtl/pair_fifo.sv
// Synchronous first-word-fall-through FIFO.
// Assumes: the owner never pushes when full nor pops when empty;
// a push and a pop may share a cycle. Any depth of 1 or more is allowed.
module pair_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = store[rd_ptr];

    // Next position of a pointer, wrapping at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the entry storage.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    // Move pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R1/R3: the owner must respect full and empty.
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/burst_packer.sv
// Collects write-data beats into one whole-burst word.
// Assumes: beat_fire is already qualified by the FIFO ready flag.
// A burst closes on the last flag or on beat BEATS-1, whichever comes first.
// Slots never written are filled with zero data and an all-ones mask.
module burst_packer #(
    parameter int DW    = 32,
    parameter int BEATS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beat_fire,
    input  logic [DW-1:0]           beat_data,
    input  logic [DW/8-1:0]         beat_mask,
    input  logic                    beat_last,
    output logic                    burst_push,
    output logic [BEATS*DW-1:0]     burst_data,
    output logic [BEATS*DW/8-1:0]   burst_mask,
    output logic                    burst_start,
    output logic                    err_short,
    output logic                    err_long
);
    localparam int MW = DW / 8;
    localparam int IW = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [IW-1:0] beat_idx;
    logic [DW-1:0] hold_data [BEATS];
    logic [MW-1:0] hold_mask [BEATS];
    logic          on_final;

    assign on_final    = (beat_idx == IW'(BEATS - 1));
    assign burst_start = beat_fire && (beat_idx == '0);
    assign burst_push  = beat_fire && (beat_last || on_final);
    assign err_short   = beat_fire && beat_last && !on_final;
    assign err_long    = beat_fire && !beat_last && on_final;

    // Build every slot of the outgoing word from held, live or filler beats.
    for (genvar j = 0; j < BEATS; j++) begin : g_slot
        always_comb begin
            if (beat_idx == IW'(j)) begin
                burst_data[j*DW +: DW] = beat_data;
                burst_mask[j*MW +: MW] = beat_mask;
            end else if (IW'(j) < beat_idx) begin
                burst_data[j*DW +: DW] = hold_data[j];
                burst_mask[j*MW +: MW] = hold_mask[j];
            end else begin
                burst_data[j*DW +: DW] = '0;
                burst_mask[j*MW +: MW] = '1;
            end
        end
    end

    // Keep the beats already taken for the burst being collected.
    always_ff @(posedge clk) begin
        if (beat_fire) begin
            hold_data[beat_idx] <= beat_data;
            hold_mask[beat_idx] <= beat_mask;
        end
    end

    // Track the position of the next beat inside its burst.
    always_ff @(posedge clk) begin
        if (!rst_n)          beat_idx <= '0;
        else if (burst_push) beat_idx <= '0;
        else if (beat_fire)  beat_idx <= beat_idx + 1'b1;
    end

    // R4: the beat position never runs past the burst length.
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        beat_idx <= IW'(BEATS - 1));
    // R10/R11: a closed burst restarts at beat 0.
    a_r10_close_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        burst_push |=> (beat_idx == '0));
endmodule

// File: rtl/skew_watch.sv
// Measures how long each write command waits for the first beat of its burst.
// Assumes: wcmd_fire marks an accepted write command, burst_start marks the
// first accepted beat of any burst. Bursts and write commands are matched
// strictly in order. A burst that starts before its command is kept as a
// credit; a command with no burst started gets a timestamp in a small ring.
// Only the oldest waiting command can be late first, so only it is timed.
module skew_watch #(
    parameter int DEPTH     = 4,
    parameter int EARLY_MAX = 5,
    parameter int MAX_SKEW  = 3,
    parameter int TS_W      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wcmd_fire,
    input  logic burst_start,
    output logic late_err
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = $clog2(EARLY_MAX + 1);

    logic [TS_W-1:0] now;
    logic [TS_W-1:0] stamp [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr;
    logic [CW-1:0]   owed;
    logic [EW-1:0]   early;
    logic            head_flagged;
    logic            q_empty, do_push, do_pop, early_inc, early_dec;
    logic [TS_W-1:0] head_age;

    assign q_empty  = (owed == '0);
    assign head_age = now - stamp[rd_ptr];
    assign late_err = !q_empty && !head_flagged && (head_age > TS_W'(MAX_SKEW));

    // Decide how this cycle's command and burst events change the books.
    always_comb begin
        do_push   = 1'b0;
        do_pop    = 1'b0;
        early_inc = 1'b0;
        early_dec = 1'b0;
        if (wcmd_fire && burst_start) begin
            do_push = !q_empty;
            do_pop  = !q_empty;
        end else if (wcmd_fire) begin
            if (early != '0) early_dec = 1'b1;
            else             do_push   = 1'b1;
        end else if (burst_start) begin
            if (!q_empty) do_pop    = 1'b1;
            else          early_inc = 1'b1;
        end
    end

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Free-running cycle stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    // Record when each unmatched write command was taken.
    always_ff @(posedge clk) begin
        if (do_push) stamp[wr_ptr] <= now;
    end

    // Maintain the ring, the credit count and the once-only late marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr       <= '0;
            wr_ptr       <= '0;
            owed         <= '0;
            early        <= '0;
            head_flagged <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      owed <= owed + 1'b1;
            else if (do_pop && !do_push) owed <= owed - 1'b1;
            if (early_inc)      early <= early + 1'b1;
            else if (early_dec) early <= early - 1'b1;
            if (do_pop)        head_flagged <= 1'b0;
            else if (late_err) head_flagged <= 1'b1;
        end
    end

    // R9: credits and waiting commands never coexist.
    a_r9_credit_xor_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (early != '0) |-> q_empty);
    // R8: one late report per waiting command.
    a_r8_single_report: assert property (@(posedge clk) disable iff (!rst_n)
        (late_err && !do_pop) |=> !late_err);
    a_r8_ring_bound: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |-> (owed < CW'(DEPTH) || do_pop));
endmodule

// File: rtl/mem_cmd_pair_frontend.sv
// Command / write-data pairing front end.
// Takes commands and write beats on two independent handshaked channels,
// buffers each in its own FIFO, pairs every write with the oldest complete
// burst and offers in-order operations to a downstream port. Error pulses
// are registered and appear one cycle after their cause.
// Assumes: downstream follows valid/ready; op_* are held while stalled.
module mem_cmd_pair_frontend
    import mem_pair_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int BEATS      = 2,
    parameter int CMD_DEPTH  = 4,
    parameter int DATA_DEPTH = 4,
    parameter int MAX_SKEW   = 3,
    parameter int TS_W       = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [2:0]               cmd_code,
    input  logic [AW-1:0]            cmd_addr,
    input  logic                     wd_valid,
    output logic                     wd_ready,
    input  logic [DW-1:0]            wd_data,
    input  logic [DW/8-1:0]          wd_mask,
    input  logic                     wd_last,
    output logic                     op_valid,
    input  logic                     op_ready,
    output logic                     op_write,
    output logic [AW-1:0]            op_addr,
    output logic [BEATS*DW-1:0]      op_data,
    output logic [BEATS*DW/8-1:0]    op_mask,
    output logic [ERR_W-1:0]         err_flags
);
    localparam int MW    = DW / 8;
    localparam int CMD_W = AW + 1;
    localparam int BUR_W = BEATS * (DW + MW);

    logic             cmd_fire, code_known, cmd_push, wcmd_fire, bad_code;
    logic             c_empty, c_full, d_empty, d_full;
    logic [CMD_W-1:0] c_head;
    logic [BUR_W-1:0] d_head, d_push_word;
    logic             beat_fire, b_push, b_start, b_short, b_long, late;
    logic [BEATS*DW-1:0] b_data;
    logic [BEATS*MW-1:0] b_mask;
    logic             op_fire, head_is_write;

    // Command channel acceptance and decode.
    assign cmd_ready  = !c_full;
    assign cmd_fire   = cmd_valid && cmd_ready;
    assign code_known = (cmd_code == CODE_WRITE) || (cmd_code == CODE_READ);
    assign cmd_push   = cmd_fire && code_known;
    assign wcmd_fire  = cmd_fire && (cmd_code == CODE_WRITE);
    assign bad_code   = cmd_fire && !code_known;

    // Data channel acceptance.
    assign wd_ready  = !d_full;
    assign beat_fire = wd_valid && wd_ready;

    pair_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (cmd_push),
        .push_data({cmd_code == CODE_WRITE, cmd_addr}),
        .pop      (op_fire),
        .head     (c_head),
        .empty    (c_empty),
        .full     (c_full)
    );

    burst_packer #(.DW(DW), .BEATS(BEATS)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_fire  (beat_fire),
        .beat_data  (wd_data),
        .beat_mask  (wd_mask),
        .beat_last  (wd_last),
        .burst_push (b_push),
        .burst_data (b_data),
        .burst_mask (b_mask),
        .burst_start(b_start),
        .err_short  (b_short),
        .err_long   (b_long)
    );

    assign d_push_word = {b_mask, b_data};

    pair_fifo #(.W(BUR_W), .DEPTH(DATA_DEPTH)) u_data_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (b_push),
        .push_data(d_push_word),
        .pop      (op_fire && head_is_write),
        .head     (d_head),
        .empty    (d_empty),
        .full     (d_full)
    );

    skew_watch #(
        .DEPTH    (CMD_DEPTH),
        .EARLY_MAX(DATA_DEPTH + 1),
        .MAX_SKEW (MAX_SKEW),
        .TS_W     (TS_W)
    ) u_skew (
        .clk        (clk),
        .rst_n      (rst_n),
        .wcmd_fire  (wcmd_fire),
        .burst_start(b_start),
        .late_err   (late)
    );

    // Offer the head command; a write also needs a complete burst.
    assign head_is_write = c_head[AW];
    assign op_valid      = !c_empty && (!head_is_write || !d_empty);
    assign op_fire       = op_valid && op_ready;
    assign op_write      = head_is_write;
    assign op_addr       = c_head[AW-1:0];
    assign op_data       = head_is_write ? d_head[BEATS*DW-1:0] : '0;
    assign op_mask       = head_is_write ? d_head[BUR_W-1:BEATS*DW] : '1;

    // Register the error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flags <= '0;
        end else begin
            err_flags[ERR_BAD_CODE] <= bad_code;
            err_flags[ERR_LATE]     <= late;
            err_flags[ERR_SHORT]    <= b_short;
            err_flags[ERR_LONG]     <= b_long;
        end
    end

    // R7: a stalled operation keeps its contents.
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_write) &&
            $stable(op_addr) && $stable(op_data) && $stable(op_mask)));
    // R5: a write leaves only with a complete burst queued.
    a_r5_write_paired: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && op_write) |-> !d_empty);
    // R2: an unsupported code leaves the command queue untouched.
    a_r2_bad_code_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_code && c_empty) |=> c_empty);
    // R12: error pulses come only from a preceding cause.
    a_r12_err_caused: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[ERR_BAD_CODE] |-> $past(cmd_valid));
endmodule

// File: tb/sim_mem_cmd_pair_frontend.sv
module sim_mem_cmd_pair_frontend;
    localparam int AW = 16, DW = 32, BEATS = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, cmd_ready;
    logic [2:0] cmd_code = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic wd_valid = 0, wd_ready, wd_last = 0;
    logic [DW-1:0] wd_data = 0;
    logic [3:0] wd_mask = 0;
    logic op_valid, op_ready = 0, op_write;
    logic [AW-1:0] op_addr;
    logic [63:0] op_data;
    logic [7:0] op_mask;
    logic [3:0] err_flags;

    int checks = 0, errors = 0, cycles = 0;
    int n_ops = 0;
    logic [3:0] err_seen = 0;
    logic        rec_w    [64];
    logic [15:0] rec_addr [64];
    logic [63:0] rec_data [64];
    logic [7:0]  rec_mask [64];

    always #10 clk = ~clk;

    mem_cmd_pair_frontend u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data), .wd_mask(wd_mask), .wd_last(wd_last),
        .op_valid(op_valid), .op_ready(op_ready), .op_write(op_write), .op_addr(op_addr),
        .op_data(op_data), .op_mask(op_mask), .err_flags(err_flags)
    );

    // Record accepted operations and gathered error pulses.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            err_seen <= err_seen | err_flags;
            if (op_valid && op_ready && n_ops < 64) begin
                rec_w[n_ops]    <= op_write;
                rec_addr[n_ops] <= op_addr;
                rec_data[n_ops] <= op_data;
                rec_mask[n_ops] <= op_mask;
                n_ops <= n_ops + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            check(1'b0, "watchdog", 64'(cycles), 64'd100000);
            summary();
        end
    end

    task automatic put_cmd(input logic [2:0] code, input logic [15:0] addr);
        bit took;
        @(negedge clk);
        cmd_valid = 1; cmd_code = code; cmd_addr = addr;
        took = 0;
        while (!took) begin
            took = cmd_ready;
            @(posedge clk);
            if (!took) @(negedge clk);
        end
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic put_beat(input logic [31:0] d, input logic [3:0] m, input logic last);
        bit took;
        @(negedge clk);
        wd_valid = 1; wd_data = d; wd_mask = m; wd_last = last;
        took = 0;
        while (!took) begin
            took = wd_ready;
            @(posedge clk);
            if (!took) @(negedge clk);
        end
        @(negedge clk);
        wd_valid = 0; wd_last = 0;
    endtask

    // Back-to-back two-beat burst, no gaps.
    task automatic put_burst(input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        wd_valid = 1; wd_data = d0; wd_mask = 0; wd_last = 0;
        @(posedge clk);
        @(negedge clk);
        wd_data = d1; wd_last = 1;
        @(posedge clk);
        @(negedge clk);
        wd_valid = 0; wd_last = 0;
    endtask

    task automatic wait_ops(input int target);
        for (int i = 0; i < 40 && n_ops < target; i++) @(negedge clk);
    endtask

    task automatic clr_err();
        @(negedge clk);
        err_seen = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cmd_ready == 1, "R12 cmd_ready", 64'(cmd_ready), 1);
        check(wd_ready == 1, "R12 wd_ready", 64'(wd_ready), 1);
        check(op_valid == 0, "R12 op_valid", 64'(op_valid), 0);
        check(err_flags == 0, "R12 err_flags", 64'(err_flags), 0);
    endtask

    task automatic t_read();
        int base = n_ops;
        op_ready = 1;
        clr_err();
        put_cmd(3'd1, 16'h0010);
        wait_ops(base + 1);
        check(n_ops == base + 1, "R6 read issued", 64'(n_ops), 64'(base + 1));
        check(rec_w[base] == 0 && rec_addr[base] == 16'h0010, "R6 read fields",
              {47'd0, rec_w[base], rec_addr[base]}, 64'h0010);
    endtask

    task automatic t_write_aligned();
        int base = n_ops;
        clr_err();
        fork
            put_cmd(3'd0, 16'h0100);
            put_burst(32'hA0A0_0001, 32'hA0A0_0002);
        join
        wait_ops(base + 1);
        check(rec_w[base] == 1 && rec_addr[base] == 16'h0100, "R5 write addr",
              64'(rec_addr[base]), 64'h0100);
        check(rec_data[base] == 64'hA0A0_0002_A0A0_0001, "R4 burst data order",
              rec_data[base], 64'hA0A0_0002_A0A0_0001);
        check(rec_mask[base] == 8'h00, "R5 mask", 64'(rec_mask[base]), 0);
        repeat (3) @(negedge clk);
        check(err_seen == 0, "R9 same-cycle no error", 64'(err_seen), 0);
    endtask

    task automatic t_single_early();
        int base = n_ops;
        clr_err();
        put_burst(32'hB0B0_0001, 32'hB0B0_0002);
        repeat (5) @(negedge clk);
        check(n_ops == base, "R5 no write without command", 64'(n_ops), 64'(base));
        put_cmd(3'd0, 16'h0200);
        wait_ops(base + 1);
        check(rec_data[base] == 64'hB0B0_0002_B0B0_0001, "R9 early data paired",
              rec_data[base], 64'hB0B0_0002_B0B0_0001);
        repeat (3) @(negedge clk);
        check(err_seen == 0, "R9 early no error", 64'(err_seen), 0);
    endtask

    task automatic t_late();
        int base = n_ops;
        clr_err();
        put_cmd(3'd0, 16'h0300);
        repeat (6) @(negedge clk);
        check(op_valid == 0, "R5 write waits for data", 64'(op_valid), 0);
        put_burst(32'hC0C0_0001, 32'hC0C0_0002);
        wait_ops(base + 1);
        repeat (2) @(negedge clk);
        check(err_seen == 4'b0010, "R8 late flag", 64'(err_seen), 64'h2);
        check(rec_data[base] == 64'hC0C0_0002_C0C0_0001, "R8 late write issued",
              rec_data[base], 64'hC0C0_0002_C0C0_0001);
    endtask

    task automatic t_order();
        int base = n_ops;
        logic [15:0] a0;
        clr_err();
        op_ready = 0;
        fork
            begin
                put_cmd(3'd0, 16'h0401);
                put_cmd(3'd1, 16'h0402);
                put_cmd(3'd0, 16'h0403);
            end
            begin
                put_burst(32'hD0D0_0001, 32'hD0D0_0002);
                put_burst(32'hD0D0_0003, 32'hD0D0_0004);
            end
        join
        @(negedge clk);
        a0 = op_addr;
        repeat (3) begin
            @(negedge clk);
            check(op_valid == 1 && op_addr == a0 && op_data == 64'hD0D0_0002_D0D0_0001,
                  "R7 stalled op stable", 64'(op_addr), 64'(a0));
        end
        op_ready = 1;
        wait_ops(base + 3);
        check(rec_addr[base] == 16'h0401 && rec_addr[base+1] == 16'h0402 && rec_addr[base+2] == 16'h0403,
              "R7 order", {16'd0, rec_addr[base], rec_addr[base+1], rec_addr[base+2]}, 64'h0401_0402_0403);
        check(rec_w[base+1] == 0 && rec_data[base+2] == 64'hD0D0_0004_D0D0_0003,
              "R6 R5 interleaved", rec_data[base+2], 64'hD0D0_0004_D0D0_0003);
        check(err_seen == 0, "R9 interleave no error", 64'(err_seen), 0);
    endtask

    task automatic t_backpressure();
        int base = n_ops;
        clr_err();
        op_ready = 0;
        for (int i = 0; i < 4; i++) put_burst(32'hE000_0000 + 2*i, 32'hE000_0001 + 2*i);
        @(negedge clk);
        check(wd_ready == 0, "R3 data full", 64'(wd_ready), 0);
        for (int i = 0; i < 4; i++) put_cmd(3'd1, 16'h0500 + 16'(i));
        @(negedge clk);
        check(cmd_ready == 0, "R1 cmd full", 64'(cmd_ready), 0);
        cmd_valid = 1; cmd_code = 3'd1; cmd_addr = 16'h05FF;
        repeat (3) @(negedge clk);
        cmd_valid = 0;
        op_ready = 1;
        wait_ops(base + 4);
        repeat (4) @(negedge clk);
        check(n_ops == base + 4, "R1 refused cmd not taken", 64'(n_ops), 64'(base + 4));
        for (int i = 0; i < 4; i++) put_cmd(3'd0, 16'h0600 + 16'(i));
        wait_ops(base + 8);
        for (int i = 0; i < 4; i++)
            check(rec_w[base+4+i] == 1 &&
                  rec_data[base+4+i] == {32'hE000_0001 + 32'(2*i), 32'hE000_0000 + 32'(2*i)},
                  "R5 early bursts paired", rec_data[base+4+i],
                  {32'hE000_0001 + 32'(2*i), 32'hE000_0000 + 32'(2*i)});
        check(err_seen == 0, "R9 early burst credits no error", 64'(err_seen), 0);
    endtask

    task automatic t_bad_code();
        int base = n_ops;
        clr_err();
        put_cmd(3'd3, 16'h0700);
        repeat (4) @(negedge clk);
        check(err_seen == 4'b0001, "R2 bad code flag", 64'(err_seen), 1);
        check(n_ops == base && op_valid == 0, "R2 bad code no op", 64'(n_ops), 64'(base));
    endtask

    task automatic t_short();
        int base = n_ops;
        clr_err();
        fork
            put_cmd(3'd0, 16'h0800);
            put_beat(32'hF0F0_0001, 4'h0, 1'b1);
        join
        wait_ops(base + 1);
        repeat (2) @(negedge clk);
        check(err_seen == 4'b0100, "R10 short flag", 64'(err_seen), 4);
        check(rec_data[base] == 64'h0000_0000_F0F0_0001 && rec_mask[base] == 8'hF0,
              "R10 short fill", {rec_mask[base], rec_data[base][55:0]}, 64'hF0_0000_00F0F0_0001);
    endtask

    task automatic t_long();
        int base = n_ops;
        clr_err();
        fork
            put_cmd(3'd0, 16'h0900);
            begin
                put_beat(32'h1111_0001, 4'h0, 1'b0);
                put_beat(32'h1111_0002, 4'h3, 1'b0);
            end
        join
        wait_ops(base + 1);
        repeat (2) @(negedge clk);
        check(err_seen == 4'b1000, "R11 long flag", 64'(err_seen), 8);
        check(rec_data[base] == 64'h1111_0002_1111_0001 && rec_mask[base] == 8'h30,
              "R11 long closed", rec_data[base], 64'h1111_0002_1111_0001);
        clr_err();
        fork
            put_cmd(3'd0, 16'h0901);
            put_burst(32'h2222_0001, 32'h2222_0002);
        join
        wait_ops(base + 2);
        repeat (2) @(negedge clk);
        check(rec_data[base+1] == 64'h2222_0002_2222_0001 && err_seen == 0,
              "R11 next burst clean", rec_data[base+1], 64'h2222_0002_2222_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_read();
        t_write_aligned();
        t_single_early();
        t_late();
        t_order();
        t_backpressure();
        t_bad_code();
        t_short();
        t_long();
        summary();
    end
endmodule